// File: doc/BRIEF.md
# Time-Base Bit-Tap Interval Timer

This block watches a free-running 64-bit time base and raises a one-cycle event whenever one chosen bit of that count goes from 0 to 1. Because each bit of a binary counter rises once every 2^(i+1) counts, the chosen bit sets the timer's interval. The same block serves as the fixed-interval timer or as the watchdog timer. A mode input picks which status-set output the event drives.

The bit to watch is chosen in one of two ways. In extended mode, a 4-bit extension and a 2-bit period field are joined into a 6-bit code, and the tap sits at the top bit index minus that code. Otherwise, the 2-bit period field picks one of four bit positions held in a parameter table. The status bit itself is kept outside the block and is fed back as `status_pending`. While it is set, no new event is produced. A `rearm` strobe marks the cycle in which software clears the status bit, and a rising edge in that same cycle still counts.

Top module: `tbtap_timer`

## Requirements
- R1: With `ext_mode`=1, the tapped index equals 63 minus the 6-bit code {period_ext, period_sel}, with period_ext in bits 5:2 and period_sel in bits 1:0. The index is shown on `tap_index`.
- R2: With `ext_mode`=0, `period_sel` values 0, 1, 2 and 3 select the table entries, which default to bits 17, 21, 25 and 29 of the time base.
- R3: An event occurs only when the tapped bit is 0 in one cycle's sample and 1 in the next cycle's sample. A 1-to-0 change, or a steady value, gives no event.
- R4: With `wdog_mode`=0, an event pulses `interval_set`. With `wdog_mode`=1, it pulses `watchdog_set`. The two outputs are never high together.
- R5: While `status_pending` is 1 and `rearm` is 0, a rising edge of the tapped bit produces no event.
- R6: A rising edge in the same cycle as `rearm`=1 produces an event, even if `status_pending` is still 1.
- R7: A change to the period fields or to `ext_mode` takes effect in the cycle it is applied. Both the current sample and the previous sample are compared at the newly selected index.
- R8: During reset both set outputs are 0. The first time-base sample after reset is taken only as history and cannot produce an event.
- R9: A set output goes high for exactly one cycle. It follows the clock edge that samples the rising value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_base | input | 64 | Free-running time-base count, sampled every cycle |
| period_sel | input | 2 | Period code, low part |
| period_ext | input | 4 | Period extension, high part (used in extended mode) |
| ext_mode | input | 1 | 1: computed index, 0: table lookup |
| wdog_mode | input | 1 | 0: fixed-interval role, 1: watchdog role |
| status_pending | input | 1 | Matching status bit, still set |
| rearm | input | 1 | Strobe: the status bit is being cleared this cycle |
| interval_set | output | 1 | One-cycle set pulse for the fixed-interval status bit |
| watchdog_set | output | 1 | One-cycle set pulse for the watchdog status bit |
| tap_index | output | 6 | Currently selected time-base bit index |

## Verification
The hardest situation to reach is a tap change that lands on a bit which was low in the previous sample and is high in the current one. That case must fire. Its mirror case, a change onto a bit that was already high, must stay quiet. The bench reaches both by writing time-base words with chosen bit patterns and switching the period fields in the very cycle the new word is applied. It also lines up a rising edge with a still-high pending input, once with the rearm strobe and once without it. An incrementing sweep on the lowest taps, with pending tied to a count bit, mixes suppressed and released edges.

// File: rtl/tbtap_pkg.sv
package tbtap_pkg;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_WATCHDOG = 1'b1
  } tap_mode_e;

  // Computed tap position: top bit index minus the joined period code.
  function automatic int unsigned ext_tap_index(input int unsigned msb,
                                                input int unsigned code);
    return msb - code;
  endfunction

  // Rising edge of one bit between two consecutive samples.
  function automatic logic bit_rose(input logic now_bit, input logic old_bit);
    return now_bit & ~old_bit;
  endfunction

endpackage

// File: rtl/tbtap_index_sel.sv
module tbtap_index_sel #(
  parameter int unsigned TB_W    = 64,
  parameter int unsigned PER_W   = 2,
  parameter int unsigned EXT_W   = 4,
  parameter int unsigned LUT_BIT [(1<<PER_W)] = '{17, 21, 25, 29},
  localparam int unsigned IDX_W  = $clog2(TB_W),
  localparam int unsigned SLOTS  = 1 << PER_W,
  localparam int unsigned CODE_W = PER_W + EXT_W
) (
  input  logic [PER_W-1:0] period_sel,
  input  logic [EXT_W-1:0] period_ext,
  input  logic             ext_mode,
  output logic [IDX_W-1:0] tap_index
);
  import tbtap_pkg::*;

  logic [IDX_W-1:0]  lut [SLOTS];
  logic [CODE_W-1:0] code;
  logic [IDX_W-1:0]  ext_idx;

  for (genvar g = 0; g < SLOTS; g++) begin : g_lut
    assign lut[g] = IDX_W'(LUT_BIT[g]);
  end

  assign code    = {period_ext, period_sel};
  assign ext_idx = IDX_W'(ext_tap_index(TB_W - 1, 32'(code)));

  always_comb begin
    if (ext_mode) tap_index = ext_idx;
    else          tap_index = lut[period_sel];
  end

endmodule

// File: rtl/tbtap_edge_det.sv
module tbtap_edge_det #(
  parameter int unsigned TB_W  = 64,
  localparam int unsigned IDX_W = $clog2(TB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  time_base,
  input  logic [IDX_W-1:0] tap_index,
  output logic             edge_raw,
  output logic             primed
);
  import tbtap_pkg::*;

  logic [TB_W-1:0] prev_q;
  logic            primed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= time_base;
      primed_q <= 1'b1;
    end
  end

  // Both samples are read at the index chosen now, so a retap is exact.
  assign edge_raw = primed_q & bit_rose(time_base[tap_index], prev_q[tap_index]);
  assign primed   = primed_q;

endmodule

// File: rtl/tbtap_event_gate.sv
module tbtap_event_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_raw,
  input  logic status_pending,
  input  logic rearm,
  input  logic wdog_mode,
  output logic interval_set,
  output logic watchdog_set
);
  import tbtap_pkg::*;

  tap_mode_e mode;
  logic      fire;
  logic      int_q;
  logic      wd_q;

  assign mode = tap_mode_e'(wdog_mode);
  assign fire = edge_raw & (~status_pending | rearm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      wd_q  <= 1'b0;
    end else begin
      int_q <= fire & (mode == MODE_INTERVAL);
      wd_q  <= fire & (mode == MODE_WATCHDOG);
    end
  end

  assign interval_set = int_q;
  assign watchdog_set = wd_q;

endmodule

// File: rtl/tbtap_timer.sv
module tbtap_timer #(
  parameter int unsigned TB_W    = 64,
  parameter int unsigned PER_W   = 2,
  parameter int unsigned EXT_W   = 4,
  parameter int unsigned LUT_BIT [(1<<PER_W)] = '{17, 21, 25, 29},
  localparam int unsigned IDX_W  = $clog2(TB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  time_base,
  input  logic [PER_W-1:0] period_sel,
  input  logic [EXT_W-1:0] period_ext,
  input  logic             ext_mode,
  input  logic             wdog_mode,
  input  logic             status_pending,
  input  logic             rearm,
  output logic             interval_set,
  output logic             watchdog_set,
  output logic [IDX_W-1:0] tap_index
);

  logic edge_raw;
  logic primed;

  tbtap_index_sel #(
    .TB_W(TB_W), .PER_W(PER_W), .EXT_W(EXT_W), .LUT_BIT(LUT_BIT)
  ) u_index (
    .period_sel (period_sel),
    .period_ext (period_ext),
    .ext_mode   (ext_mode),
    .tap_index  (tap_index)
  );

  tbtap_edge_det #(.TB_W(TB_W)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_base (time_base),
    .tap_index (tap_index),
    .edge_raw  (edge_raw),
    .primed    (primed)
  );

  tbtap_event_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .edge_raw       (edge_raw),
    .status_pending (status_pending),
    .rearm          (rearm),
    .wdog_mode      (wdog_mode),
    .interval_set   (interval_set),
    .watchdog_set   (watchdog_set)
  );

endmodule

// File: rtl/tbtap_timer_chk.sv
module tbtap_timer_chk #(
  parameter int unsigned PER_W = 2,
  parameter int unsigned EXT_W = 4,
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PER_W-1:0] period_sel,
  input logic [EXT_W-1:0] period_ext,
  input logic             ext_mode,
  input logic             wdog_mode,
  input logic             status_pending,
  input logic             rearm,
  input logic             interval_set,
  input logic             watchdog_set,
  input logic [IDX_W-1:0] tap_index,
  input logic             edge_raw,
  input logic             primed
);

  // R1: the all-ones code in extended mode taps bit 0.
  assert_ext_lowest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && (&period_ext) && (&period_sel)) |-> (tap_index == '0));

  // R4: each pulse matches the role that was selected at the firing edge.
  assert_interval_role_R4: assert property (@(posedge clk) disable iff (!rst_n)
    interval_set |-> $past(wdog_mode) == 1'b0);
  assert_watchdog_role_R4: assert property (@(posedge clk) disable iff (!rst_n)
    watchdog_set |-> $past(wdog_mode) == 1'b1);
  assert_one_role_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({interval_set, watchdog_set}));

  // R5: a pending status without rearm blocks the pulse.
  assert_pending_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_pending) && !$past(rearm)) |-> !(interval_set || watchdog_set));

  // R3/R9: every pulse is preceded by a detected rising edge one cycle before.
  assert_pulse_has_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_set || watchdog_set) |-> $past(edge_raw));

  // R8: no pulse follows the unprimed first sample.
  assert_first_sample_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !(interval_set || watchdog_set));

endmodule

bind tbtap_timer tbtap_timer_chk #(.PER_W(PER_W), .EXT_W(EXT_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tbtap_timer_bench.sv
module tbtap_timer_bench;

  typedef struct {
    logic        iset;
    logic        wset;
    int unsigned idx;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_base = '0;
  logic [1:0]  period_sel = '0;
  logic [3:0]  period_ext = '0;
  logic        ext_mode = 1'b0;
  logic        wdog_mode = 1'b0;
  logic        status_pending = 1'b0;
  logic        rearm = 1'b0;
  logic        interval_set;
  logic        watchdog_set;
  logic [5:0]  tap_index;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t sb_q[$];

  logic [63:0] m_prev = '0;
  logic        m_primed = 1'b0;

  always #5 clk = ~clk;

  tbtap_timer u_tbtap_timer (
    .clk(clk), .rst_n(rst_n), .time_base(time_base),
    .period_sel(period_sel), .period_ext(period_ext), .ext_mode(ext_mode),
    .wdog_mode(wdog_mode), .status_pending(status_pending), .rearm(rearm),
    .interval_set(interval_set), .watchdog_set(watchdog_set), .tap_index(tap_index)
  );

  // Requirement model: table values per R2, code arithmetic per R1.
  function automatic int unsigned m_index(logic xm, logic [3:0] ext, logic [1:0] per);
    int unsigned table_v [4] = '{17, 21, 25, 29};
    if (xm) return 63 - (int'(ext) * 4 + int'(per));
    return table_v[per];
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic apply_now(input logic [63:0] tbv, input logic [1:0] per,
                           input logic [3:0] ext, input logic xm, input logic wd,
                           input logic pd, input logic ra, input string tag);
    exp_t        e;
    int unsigned ix;
    logic        fire;
    time_base = tbv; period_sel = per; period_ext = ext; ext_mode = xm;
    wdog_mode = wd; status_pending = pd; rearm = ra;
    ix   = m_index(xm, ext, per);
    fire = m_primed && tbv[ix] && !m_prev[ix] && (!pd || ra);
    e.iset = fire && !wd;
    e.wset = fire && wd;
    e.idx  = ix;
    e.tag  = tag;
    sb_q.push_back(e);
    m_prev   = tbv;
    m_primed = 1'b1;
  endtask

  task automatic drive(input logic [63:0] tbv, input logic [1:0] per,
                       input logic [3:0] ext, input logic xm, input logic wd,
                       input logic pd, input logic ra, input string tag);
    @(negedge clk);
    apply_now(tbv, per, ext, xm, wd, pd, ra, tag);
  endtask

  // Monitor: compares one scoreboard item per clock edge.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_tests++;
      if (interval_set !== e.iset || watchdog_set !== e.wset || int'(tap_index) != int'(e.idx)) begin
        n_fail++;
        $display("FAIL %s: got iset=%b wset=%b idx=%0d, expected iset=%b wset=%b idx=%0d",
                 e.tag, interval_set, watchdog_set, tap_index, e.iset, e.wset, e.idx);
      end
    end
  end

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (interval_set !== 1'b0 || watchdog_set !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: got %b%b expected 00", interval_set, watchdog_set);
    end
    @(negedge clk);
    rst_n = 1'b1;
    apply_now(B63, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R8 first sample no event");
    drive(64'h0, 2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 falling edge ignored");
    drive(B63,   2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 R3 rise at bit 63");
    drive(B63,   2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 pulse one cycle");
    // R1: code 0b101001 = 41 gives tap 22
    drive(64'h0,        2'd1, 4'hA, 1'b1, 1'b0, 1'b0, 1'b0, "R1 setup");
    drive(64'h20_0000,  2'd1, 4'hA, 1'b1, 1'b0, 1'b0, 1'b0, "R1 neighbour bit 21 no event");
    drive(64'h60_0000,  2'd1, 4'hA, 1'b1, 1'b0, 1'b0, 1'b0, "R1 rise at bit 22");
    // R2 and R4: each table slot, alternating roles
    for (int s = 0; s < 4; s++) begin
      int unsigned b = 17 + 4 * s;
      drive(64'h0,          2'(s), 4'h3, 1'b0, s[0], 1'b0, 1'b0, "R2 setup");
      drive(64'h1 << b,     2'(s), 4'h3, 1'b0, s[0], 1'b0, 1'b0, "R2 R4 table slot rise");
    end
    // R5 and R6
    drive(64'h0,    2'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 setup");
    drive(B63,      2'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R5 pending blocks rise");
    drive(64'h0,    2'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 setup");
    drive(B63,      2'd0, 4'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R6 rearm same cycle fires");
    // R7: retap onto a bit that was low before and is high now
    drive(64'h0000_0000_0002_0000, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 setup");
    drive(64'h0000_0000_0022_0000, 2'd1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 retap onto rising bit fires");
    drive(64'h0000_0000_2222_0000, 2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 retap onto steady-high bit quiet");
    drive(64'h0000_0000_2222_0000, 2'd3, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 retap onto steady bit 29 quiet");
    // Incrementing sweep on the lowest taps with pending from a count bit
    for (int n = 0; n < 40; n++) begin
      logic [63:0] v = 64'(n);
      drive(v, (n < 20) ? 2'd3 : 2'd2, 4'hF, 1'b1, v[3], v[2], v[4] & v[0], "R3 R5 R6 count sweep");
    end
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule